// File: doc/BRIEF.md
# TDM Conference Summing Engine

This block mixes linear audio for conference calls carried on a time-division stream of up to 32 channel slots. Software tags every channel with a conference group number, or with no group at all. The engine reads one linear sample per channel slot. During each frame it builds one running total per group. In the next frame it gives every member that total minus the member's own sample, so no party hears its own voice.

The work is spread over half-slot steps with a fixed skew. A sample is added to its group total one slot after it arrives. Its own contribution is taken back out one slot before its mixed result is sent. Each result leaves one channel slot later and one frame later than the sample it belongs to. Two banks of group totals swap roles at every frame boundary: one collects while the other is read.

The A-law/µ-law select flag is not used here. It is passed straight through to the companding converters that sit around the engine.

Top module: `conf_sum_engine`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_sample` is 0 until the first input beat.
- R2: Every cycle with `in_valid`=1 yields exactly one output beat in the next cycle, with `out_chan` equal to the input's `in_chan`. A cycle with `in_valid`=0 (including a membership-write cycle) yields `out_valid`=0 in the next cycle.
- R3: The party on channel N (N < 31) of frame M receives its result on the output beat of slot N+1 in frame M+1. The party on channel 31 receives its result on the output beat of slot 0 in frame M+2. The value is the frame-M sum of the party's group minus the party's own frame-M sample.
- R4: A channel that is in no group, or that is the only member of its group, receives 0.
- R5: Results are saturated to the signed 14-bit range, from -8192 to +8191. The group totals never wrap.
- R6: Groups are independent. A sample contributes only to the group its channel belongs to in the frame of that sample.
- R7: A membership write (`cfg_we`=1 with `cfg_chan`, `cfg_join`=1 to join or 0 to leave, and `cfg_grp` a 4-bit group number) takes effect from the next frame boundary. Writes made in the middle of a frame leave that frame's mixing unchanged.
- R8: A frame boundary is the input beat carrying channel 0. Channels arrive in ascending order 0..31 within a frame, and idle cycles between beats are allowed.
- R9: `law_o` always equals `law_i`, where 1 selects A-law and 0 selects µ-law.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| law_i | input | 1 | Companding law flag (1 = A-law, 0 = µ-law) |
| law_o | output | 1 | Companding law flag passed on to the converters |
| in_valid | input | 1 | Input beat strobe, one per channel slot |
| in_chan | input | 5 | Channel slot of the input beat |
| in_sample | input | 14 | Signed linear input sample |
| cfg_we | input | 1 | Membership write strobe |
| cfg_chan | input | 5 | Channel whose membership is written |
| cfg_join | input | 1 | 1 = join group `cfg_grp`, 0 = leave all groups |
| cfg_grp | input | 4 | Conference group number |
| out_valid | output | 1 | Output beat strobe |
| out_chan | output | 5 | Channel slot of the output beat |
| out_sample | output | 14 | Signed, saturated mixed sample |

## Verification
The assertions assume that input beats and membership writes never share a cycle. They also assume that every frame delivers all channel slots in ascending order, starting at channel 0. The bench always issues membership writes in idle cycles between beats and always drives complete frames, so both assumptions hold. The bench builds its expected results from a per-frame record of the samples and of the membership in force at each frame boundary.

// File: rtl/conf_pkg.sv
package conf_pkg;
  localparam int unsigned CONF_NCH    = 32;
  localparam int unsigned CONF_NGRP   = 16;
  localparam int unsigned CONF_SAMP_W = 14;
endpackage

// File: rtl/conf_member_tbl.sv
module conf_member_tbl #(
  parameter int unsigned NCH  = conf_pkg::CONF_NCH,
  parameter int unsigned NGRP = conf_pkg::CONF_NGRP,
  localparam int unsigned CW  = $clog2(NCH),
  localparam int unsigned GW  = $clog2(NGRP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_chan,
  input  logic          wr_join,
  input  logic [GW-1:0] wr_grp,
  input  logic          frame_adv,
  input  logic [CW-1:0] add_ch,
  output logic          add_join,
  output logic [GW-1:0] add_grp,
  input  logic [CW-1:0] sub_ch,
  output logic          sub_join,
  output logic [GW-1:0] sub_grp
);
  // pending table (written by the port), collect table (frame being summed),
  // read table (frame whose sums are being handed out)
  logic [NCH-1:0] pend_j, pend_j_n, col_j, col_j_n, rd_j, rd_j_n;
  logic [GW-1:0]  pend_g   [NCH];
  logic [GW-1:0]  pend_g_n [NCH];
  logic [GW-1:0]  col_g    [NCH];
  logic [GW-1:0]  col_g_n  [NCH];
  logic [GW-1:0]  rd_g     [NCH];
  logic [GW-1:0]  rd_g_n   [NCH];

  always_comb begin
    pend_j_n = pend_j;
    pend_g_n = pend_g;
    col_j_n  = col_j;
    col_g_n  = col_g;
    rd_j_n   = rd_j;
    rd_g_n   = rd_g;
    if (wr_en) begin
      pend_j_n[wr_chan] = wr_join;
      pend_g_n[wr_chan] = wr_grp;
    end
    if (frame_adv) begin
      col_j_n = pend_j;
      col_g_n = pend_g;
      rd_j_n  = col_j;
      rd_g_n  = col_g;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_j <= '0;
      col_j  <= '0;
      rd_j   <= '0;
      for (int i = 0; i < NCH; i++) begin
        pend_g[i] <= '0;
        col_g[i]  <= '0;
        rd_g[i]   <= '0;
      end
    end else begin
      pend_j <= pend_j_n;
      col_j  <= col_j_n;
      rd_j   <= rd_j_n;
      pend_g <= pend_g_n;
      col_g  <= col_g_n;
      rd_g   <= rd_g_n;
    end
  end

  assign add_join = col_j[add_ch];
  assign add_grp  = col_g[add_ch];
  assign sub_join = rd_j[sub_ch];
  assign sub_grp  = rd_g[sub_ch];
endmodule

// File: rtl/conf_accum_banks.sv
module conf_accum_banks #(
  parameter int unsigned NGRP   = conf_pkg::CONF_NGRP,
  parameter int unsigned SAMP_W = conf_pkg::CONF_SAMP_W,
  parameter int unsigned ACC_W  = SAMP_W + 5,
  localparam int unsigned GW    = $clog2(NGRP)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bank_sel,
  input  logic                     frame_adv,
  input  logic                     add_en,
  input  logic [GW-1:0]            add_grp,
  input  logic signed [SAMP_W-1:0] add_val,
  input  logic [GW-1:0]            rd_grp,
  output logic signed [ACC_W-1:0]  rd_sum
);
  logic signed [ACC_W-1:0] acc   [2][NGRP];
  logic signed [ACC_W-1:0] acc_n [2][NGRP];

  always_comb begin
    acc_n = acc;
    if (add_en)
      acc_n[bank_sel][add_grp] = acc[bank_sel][add_grp] + ACC_W'(add_val);
    if (frame_adv)
      for (int g = 0; g < NGRP; g++)
        acc_n[~bank_sel][g] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int g = 0; g < NGRP; g++)
          acc[b][g] <= '0;
    end else begin
      acc <= acc_n;
    end
  end

  // the bank not being collected holds last frame's finished totals
  assign rd_sum = acc[~bank_sel][rd_grp];
endmodule

// File: rtl/conf_sample_store.sv
module conf_sample_store #(
  parameter int unsigned NCH    = conf_pkg::CONF_NCH,
  parameter int unsigned SAMP_W = conf_pkg::CONF_SAMP_W,
  localparam int unsigned CW    = $clog2(NCH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_bank,
  input  logic [CW-1:0]            wr_ch,
  input  logic signed [SAMP_W-1:0] wr_val,
  input  logic                     rd_bank,
  input  logic [CW-1:0]            rd_ch,
  output logic signed [SAMP_W-1:0] rd_val
);
  logic signed [SAMP_W-1:0] mem   [2][NCH];
  logic signed [SAMP_W-1:0] mem_n [2][NCH];

  always_comb begin
    mem_n = mem;
    if (wr_en) mem_n[wr_bank][wr_ch] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < NCH; c++)
          mem[b][c] <= '0;
    end else begin
      mem <= mem_n;
    end
  end

  assign rd_val = mem[rd_bank][rd_ch];
endmodule

// File: rtl/conf_out_stage.sv
module conf_out_stage #(
  parameter int unsigned NCH    = conf_pkg::CONF_NCH,
  parameter int unsigned SAMP_W = conf_pkg::CONF_SAMP_W,
  parameter int unsigned ACC_W  = SAMP_W + 5,
  localparam int unsigned CW    = $clog2(NCH),
  localparam int unsigned DW    = ACC_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     beat,
  input  logic [CW-1:0]            beat_chan,
  input  logic                     member,
  input  logic signed [ACC_W-1:0]  grp_sum,
  input  logic signed [SAMP_W-1:0] own,
  output logic                     out_valid,
  output logic [CW-1:0]            out_chan,
  output logic signed [SAMP_W-1:0] out_sample
);
  localparam int MAXI = (1 <<< (SAMP_W - 1)) - 1;
  localparam int MINI = -(1 <<< (SAMP_W - 1));
  localparam logic signed [DW-1:0] HI = DW'(MAXI);
  localparam logic signed [DW-1:0] LO = DW'(MINI);

  logic signed [DW-1:0]     diff;
  logic signed [SAMP_W-1:0] mixed;
  logic                     valid_n;
  logic [CW-1:0]            chan_n;
  logic signed [SAMP_W-1:0] samp_n;

  always_comb begin
    diff = DW'(grp_sum) - DW'(own);
    if (diff > HI)      mixed = HI[SAMP_W-1:0];
    else if (diff < LO) mixed = LO[SAMP_W-1:0];
    else                mixed = diff[SAMP_W-1:0];
    valid_n = beat;
    chan_n  = beat ? beat_chan : out_chan;
    samp_n  = beat ? (member ? mixed : '0) : out_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_sample <= '0;
    end else begin
      out_valid  <= valid_n;
      out_chan   <= chan_n;
      out_sample <= samp_n;
    end
  end
endmodule

// File: rtl/conf_sum_engine.sv
module conf_sum_engine #(
  parameter int unsigned NCH    = conf_pkg::CONF_NCH,
  parameter int unsigned NGRP   = conf_pkg::CONF_NGRP,
  parameter int unsigned SAMP_W = conf_pkg::CONF_SAMP_W,
  localparam int unsigned CW    = $clog2(NCH),
  localparam int unsigned GW    = $clog2(NGRP),
  localparam int unsigned ACC_W = SAMP_W + CW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              law_i,
  output logic              law_o,
  input  logic              in_valid,
  input  logic [CW-1:0]     in_chan,
  input  logic [SAMP_W-1:0] in_sample,
  input  logic              cfg_we,
  input  logic [CW-1:0]     cfg_chan,
  input  logic              cfg_join,
  input  logic [GW-1:0]     cfg_grp,
  output logic              out_valid,
  output logic [CW-1:0]     out_chan,
  output logic [SAMP_W-1:0] out_sample
);
  // reset: asserted at once, released after two clock edges
  logic rs_q1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_q1      <= 1'b1;
      rst_sync_n <= rs_q1;
    end
  end

  assign law_o = law_i;

  // frame control
  logic                     bank, bank_n;
  logic                     hold_vld, hold_vld_n;
  logic [CW-1:0]            hold_ch, hold_ch_n;
  logic signed [SAMP_W-1:0] hold_x, hold_x_n;
  logic                     frame_adv;
  logic [CW-1:0]            sub_ch;

  always_comb begin
    frame_adv  = in_valid && (in_chan == '0);
    bank_n     = frame_adv ? ~bank : bank;
    hold_vld_n = hold_vld | in_valid;
    hold_ch_n  = in_valid ? in_chan : hold_ch;
    hold_x_n   = in_valid ? $signed(in_sample) : hold_x;
    sub_ch     = (in_chan == '0) ? CW'(NCH - 1) : in_chan - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bank     <= 1'b0;
      hold_vld <= 1'b0;
      hold_ch  <= '0;
      hold_x   <= '0;
    end else begin
      bank     <= bank_n;
      hold_vld <= hold_vld_n;
      hold_ch  <= hold_ch_n;
      hold_x   <= hold_x_n;
    end
  end

  logic                     add_join, sub_join;
  logic [GW-1:0]            add_grp, sub_grp;
  logic signed [ACC_W-1:0]  grp_sum;
  logic signed [SAMP_W-1:0] own_x;
  logic signed [SAMP_W-1:0] mix_out;

  conf_member_tbl #(.NCH(NCH), .NGRP(NGRP)) u_tbl (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(cfg_we), .wr_chan(cfg_chan), .wr_join(cfg_join), .wr_grp(cfg_grp),
    .frame_adv(frame_adv),
    .add_ch(hold_ch), .add_join(add_join), .add_grp(add_grp),
    .sub_ch(sub_ch), .sub_join(sub_join), .sub_grp(sub_grp)
  );

  // the sample held from the previous slot is added in this slot
  conf_accum_banks #(.NGRP(NGRP), .SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n),
    .bank_sel(bank), .frame_adv(frame_adv),
    .add_en(in_valid && hold_vld && add_join), .add_grp(add_grp), .add_val(hold_x),
    .rd_grp(sub_grp), .rd_sum(grp_sum)
  );

  conf_sample_store #(.NCH(NCH), .SAMP_W(SAMP_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(in_valid), .wr_bank(bank_n), .wr_ch(in_chan), .wr_val($signed(in_sample)),
    .rd_bank(~bank), .rd_ch(sub_ch), .rd_val(own_x)
  );

  conf_out_stage #(.NCH(NCH), .SAMP_W(SAMP_W), .ACC_W(ACC_W)) u_out (
    .clk(clk), .rst_n(rst_sync_n),
    .beat(in_valid), .beat_chan(in_chan),
    .member(sub_join), .grp_sum(grp_sum), .own(own_x),
    .out_valid(out_valid), .out_chan(out_chan), .out_sample(mix_out)
  );

  assign out_sample = mix_out;
endmodule

// File: rtl/conf_sum_engine_chk.sv
module conf_sum_engine_chk #(
  parameter int unsigned CW = 5,
  parameter int unsigned SW = 14
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic          in_valid,
  input logic [CW-1:0] in_chan,
  input logic          cfg_we,
  input logic          sub_join,
  input logic          out_valid,
  input logic [CW-1:0] out_chan,
  input logic [SW-1:0] out_sample
);
  always_comb begin
    if (!rst_sync_n) begin
      assert_reset_quiet_R1: assert (!out_valid && out_sample == '0);
    end
  end

  assert_beat_follows_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  assert_chan_echo_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_chan == $past(in_chan));

  assert_silent_outsider_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && !sub_join) |=> out_sample == '0);

  assert_cfg_idle_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_we |=> !out_valid);
endmodule

bind conf_sum_engine conf_sum_engine_chk #(.CW(CW), .SW(SAMP_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n),
  .in_valid(in_valid), .in_chan(in_chan), .cfg_we(cfg_we),
  .sub_join(sub_join),
  .out_valid(out_valid), .out_chan(out_chan), .out_sample(out_sample)
);

// File: tb/conf_sum_engine_bench.sv
module conf_sum_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        law_i, law_o;
  logic        in_valid;
  logic [4:0]  in_chan;
  logic [13:0] in_sample;
  logic        cfg_we;
  logic [4:0]  cfg_chan;
  logic        cfg_join;
  logic [3:0]  cfg_grp;
  logic        out_valid;
  logic [4:0]  out_chan;
  logic [13:0] out_sample;

  always #2 clk = ~clk;

  conf_sum_engine u_conf_sum_engine (
    .clk(clk), .rst_n(rst_n), .law_i(law_i), .law_o(law_o),
    .in_valid(in_valid), .in_chan(in_chan), .in_sample(in_sample),
    .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_join(cfg_join), .cfg_grp(cfg_grp),
    .out_valid(out_valid), .out_chan(out_chan), .out_sample(out_sample)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model: per-frame samples and membership in force
  int fr = -1;
  int hx [0:63][0:31];
  bit hj [0:63][0:31];
  int hg [0:63][0:31];
  bit sj [0:31];
  int sg [0:31];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat14(input int v);
    if (v > 8191) return 8191;
    if (v < -8192) return -8192;
    return v;
  endfunction

  function automatic int expect_mix(input int c);
    int q, d, s;
    q = (c + 31) % 32;
    d = (c == 0) ? fr - 2 : fr - 1;
    if (d < 0) return 0;
    if (!hj[d][q]) return 0;
    s = 0;
    for (int k = 0; k < 32; k++)
      if (hj[d][k] && hg[d][k] == hg[d][q]) s += hx[d][k];
    return sat14(s - hx[d][q]);
  endfunction

  task automatic beat(input int c, input int x, input string req);
    int e;
    if (c == 0) begin
      fr++;
      for (int k = 0; k < 32; k++) begin
        hj[fr][k] = sj[k];
        hg[fr][k] = sg[k];
      end
    end
    hx[fr][c] = x;
    e = expect_mix(c);
    in_valid  = 1'b1;
    in_chan   = 5'(c);
    in_sample = 14'(x);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_chan == 5'(c), "R2 beat/chan", int'(out_chan), c);
    check($signed(out_sample) == e, req, int'($signed(out_sample)), e);
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
    check(!out_valid, "R2 idle cycle", int'(out_valid), 0);
  endtask

  task automatic cfg(input int ch, input bit j, input int g);
    cfg_we = 1'b1; cfg_chan = 5'(ch); cfg_join = j; cfg_grp = 4'(g);
    sj[ch] = j; sg[ch] = g;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
    check(!out_valid, "R7 write cycle is idle", int'(out_valid), 0);
  endtask

  function automatic int pat(input int f, input int c);
    return ((c * 37 + f * 101) % 2000) - 1000;
  endfunction

  task automatic frame_pat(input int seed, input string req);
    for (int c = 0; c < 32; c++) beat(c, pat(seed, c), req);
  endtask

  // R1, R9
  task automatic t_reset();
    check(!out_valid, "R1 reset valid", int'(out_valid), 0);
    check(out_sample == '0, "R1 reset sample", int'(out_sample), 0);
    law_i = 1'b1; #1;
    check(law_o == 1'b1, "R9 A-law flag", int'(law_o), 1);
    law_i = 1'b0; #1;
    check(law_o == 1'b0, "R9 mu-law flag", int'(law_o), 0);
  endtask

  // R3, R4, R6, R8: several groups, wrap channels, outsiders and a lone member
  task automatic t_conference();
    cfg(3, 1, 2); cfg(4, 1, 2); cfg(7, 1, 2);
    cfg(0, 1, 5); cfg(15, 1, 5); cfg(31, 1, 5);
    cfg(20, 1, 9);
    frame_pat(1, "R3 first frame");
    frame_pat(2, "R3 mix one slot and one frame later");
    frame_pat(3, "R6 independent groups");
    frame_pat(4, "R4 outsider and lone member silent");
  endtask

  // R7: mid-frame writes apply at the next boundary only
  task automatic t_midframe();
    for (int c = 0; c < 11; c++) beat(c, pat(5, c), "R7 before write");
    cfg(3, 0, 0);
    cfg(5, 1, 2);
    for (int c = 11; c < 32; c++) beat(c, pat(5, c), "R7 old table this frame");
    frame_pat(6, "R7 new table next frame");
    frame_pat(7, "R7 new table settled");
  endtask

  // R5: saturation both ways
  task automatic t_saturate();
    for (int c = 8; c < 18; c++) cfg(c, 1, 1);
    for (int c = 21; c < 31; c++) cfg(c, 1, 3);
    for (int f = 0; f < 3; f++)
      for (int c = 0; c < 32; c++)
        beat(c, (c >= 8 && c < 18) ? 8000 : ((c >= 21 && c < 31) ? -8192 : pat(f, c)),
             "R5 saturated mix");
  endtask

  // R2, R8: idle gaps between beats
  task automatic t_gaps();
    for (int f = 0; f < 2; f++)
      for (int c = 0; c < 32; c++) begin
        beat(c, pat(f + 9, c), "R8 frame with gaps");
        if (c % 5 == 0) idle();
      end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 32; k++) begin sj[k] = 0; sg[k] = 0; end
    rst_n = 1'b0; law_i = 1'b0; in_valid = 1'b0; in_chan = '0; in_sample = '0;
    cfg_we = 1'b0; cfg_chan = '0; cfg_join = 1'b0; cfg_grp = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && out_sample == '0, "R1 after release", int'(out_sample), 0);
    t_conference();
    t_midframe();
    t_saturate();
    t_gaps();
    frame_pat(12, "R3 flush");
    finish_run();
  end
endmodule